// File: doc/BRIEF.md
# GPIO Interrupt Detector and Aggregator

This block watches the already-synchronized levels of a bank of general-purpose pins and turns the configured activity on each one into a sticky pending flag. Two configuration bits per pin pick the trigger kind. A mode bit chooses edge or level sensing. A polarity bit then chooses rising or falling in edge mode, and active-high or active-low in level mode. A separate per-pin sense enable gates detection entirely.

The sticky flags are grouped into 32-bit words. Software clears them by writing ones to a word. A parallel set of enable words masks them. Every flag that is both set and enabled feeds a single registered interrupt line toward the upstream interrupt controller. Register address decoding and routing of the interrupt line lie outside the block. The block receives one write strobe for the flag words and one for the enable words, together with a word index and the data.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: With mode bit 0 and polarity bit 0, a pin whose level is 1 in the current cycle and was 0 in the previous cycle sets its status bit at the clock edge that samples the 1. A steady level or a 1-to-0 change does not set it.
- R2: With mode bit 0 and polarity bit 1, a 1-to-0 change between consecutive cycles sets the status bit. A steady level or a 0-to-1 change does not set it.
- R3: With mode bit 1 and polarity bit 0, the status bit is set at every edge while the pin is 0. A clear write while the pin stays 0 therefore leaves the bit set.
- R4: With mode bit 1 and polarity bit 1, the status bit is set at every edge while the pin is 1.
- R5: A status write with word index w clears status bit of pin 32*w+i for every data bit i that is 1. Data bits that are 0 leave their status bits unchanged.
- R6: When an event and a clear write hit the same status bit at the same edge, the bit ends set. Other bits named in the write still clear.
- R7: An enable write with word index w replaces the enable bits of pins 32*w to 32*w+31 with the data. Data bits beyond the last pin are dropped. Enable bits change only on an enable write.
- R8: irqOut is 1 exactly one edge after some pin has both its status bit and its enable bit set. It is 0 one edge after no pin does.
- R9: A pin whose sense enable is 0 never sets its status bit, whatever its level and mode.
- R10: After reset, status, enable and irqOut are all 0. Writing all ones to every status word and zero to every enable word leaves irqOut at 0.
- R11: A status or enable write whose word index is not below the number of words (3 for 95 pins) changes nothing.
- R12: At the first edge after reset no event is detected, and the level sampled there becomes the reference for edge detection. A pin held at 1 through reset in rising mode therefore does not set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pinLevel | input | NUM_PINS | Synchronized pin levels |
| senseEn | input | NUM_PINS | Per-pin input sense enable |
| trigLevel | input | NUM_PINS | Mode bit: 0 edge, 1 level |
| trigInvert | input | NUM_PINS | Polarity bit (see R1 to R4) |
| wrStatus | input | 1 | Write-one-to-clear strobe for a status word |
| wrEnable | input | 1 | Load strobe for an enable word |
| wrWordSel | input | 2 | Word index for both strobes |
| wrData | input | 32 | Write data |
| statusOut | output | NUM_PINS | Sticky status bits |
| enableOut | output | NUM_PINS | Enable bits |
| irqOut | output | 1 | Aggregated interrupt, registered |

## Verification
Detection and software clearing can land on the same status bit at the same edge. The bench provokes this in two ways. First, it raises a rising-mode pin in the very cycle that a clear of its word is written. Second, it writes clears while level-mode pins are held active. In both cases it checks after the edge that the pin with the new event stays set while another pin named in the same write is cleared. A near-exhaustive sweep over all four modes and all four level transitions, on pins at both ends of every word, compares status and the lagging interrupt line against values worked out from the mode table.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 2;

  typedef struct packed {
    logic              clrStb;
    logic              enStb;
    logic [SEL_W-1:0]  word;
    logic [WORD_W-1:0] data;
    logic              armed;
  } irqStrobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStatus,
  input  logic              wrEnable,
  input  logic [SEL_W-1:0]  wrWordSel,
  input  logic [WORD_W-1:0] wrData,
  output irqStrobes_t       strobes
);
  logic armedQ;
  logic inRange;

  // Detection is held off for the first edge so the level reference is primed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armedQ <= 1'b0;
    else        armedQ <= 1'b1;
  end

  assign inRange = (int'(wrWordSel) < NUM_WORDS);

  always_comb begin
    strobes.clrStb = wrStatus & inRange;
    strobes.enStb  = wrEnable & inRange;
    strobes.word   = wrWordSel;
    strobes.data   = wrData;
    strobes.armed  = armedQ;
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 95
) (
  input  logic                clk,
  input  logic                rst_n,
  input  irqStrobes_t         strobes,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] senseEn,
  input  logic [NUM_PINS-1:0] trigLevel,
  input  logic [NUM_PINS-1:0] trigInvert,
  output logic [NUM_PINS-1:0] statusQ,
  output logic [NUM_PINS-1:0] enableQ,
  output logic                irqQ
);
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] clrMask;
  logic [NUM_PINS-1:0] enLoad;
  logic [NUM_PINS-1:0] enData;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] levelHit;
  logic [NUM_PINS-1:0] eventHit;

  // Per-pin decode of the word-wide strobes.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WordIdx = p / WORD_W;
    localparam int BitIdx  = p % WORD_W;
    logic wordHit;
    assign wordHit    = (int'(strobes.word) == WordIdx);
    assign clrMask[p] = strobes.clrStb & wordHit & strobes.data[BitIdx];
    assign enLoad[p]  = strobes.enStb & wordHit;
    assign enData[p]  = strobes.data[BitIdx];
  end

  // Edge mode: polarity 0 rising, 1 falling. Level mode: polarity 0 low, 1 high.
  assign edgeHit  = (~trigInvert & ~prevQ & pinLevel) | (trigInvert & prevQ & ~pinLevel);
  assign levelHit = ~(pinLevel ^ trigInvert);
  assign eventHit = senseEn & {NUM_PINS{strobes.armed}} &
                    ((trigLevel & levelHit) | (~trigLevel & edgeHit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevQ   <= '0;
      statusQ <= '0;
      enableQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      prevQ   <= pinLevel;
      statusQ <= (statusQ & ~clrMask) | eventHit;
      enableQ <= (enableQ & ~enLoad) | (enData & enLoad);
      irqQ    <= |(statusQ & enableQ);
    end
  end
endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 95
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] senseEn,
  input  logic [NUM_PINS-1:0] trigLevel,
  input  logic [NUM_PINS-1:0] trigInvert,
  input  logic                wrStatus,
  input  logic                wrEnable,
  input  logic [SEL_W-1:0]    wrWordSel,
  input  logic [WORD_W-1:0]   wrData,
  output logic [NUM_PINS-1:0] statusOut,
  output logic [NUM_PINS-1:0] enableOut,
  output logic                irqOut
);
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;

  irqStrobes_t strobes;

  gpio_irq_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrStatus(wrStatus), .wrEnable(wrEnable),
    .wrWordSel(wrWordSel), .wrData(wrData), .strobes(strobes)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .pinLevel(pinLevel),
    .senseEn(senseEn), .trigLevel(trigLevel), .trigInvert(trigInvert),
    .statusQ(statusOut), .enableQ(enableOut), .irqQ(irqOut)
  );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int NUM_PINS = 95
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pinLevel,
  input logic [NUM_PINS-1:0] senseEn,
  input logic [NUM_PINS-1:0] trigLevel,
  input logic [NUM_PINS-1:0] trigInvert,
  input logic                wrEnable,
  input logic [NUM_PINS-1:0] statusOut,
  input logic [NUM_PINS-1:0] enableOut,
  input logic                irqOut
);
  logic [1:0] upCnt;
  logic [NUM_PINS-1:0] lvlActive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            upCnt <= 2'd0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  assign lvlActive = senseEn & trigLevel & ~(pinLevel ^ trigInvert);

  // R8: registered aggregation
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt != 2'd0) |-> (irqOut == $past(|(statusOut & enableOut))));

  // R9: sensing disabled never raises a status bit
  a_r9_sense_off: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt != 2'd0) |-> ((statusOut & ~$past(statusOut) & ~$past(senseEn)) == '0));

  // R3 and R4: an active level leaves its status bit set
  a_r3_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd2) |-> ((statusOut & $past(lvlActive)) == $past(lvlActive)));

  // R7: enable bits move only on an enable write
  a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEnable |=> $stable(enableOut));
endmodule

bind gpio_irq_aggregator gpio_irq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pinLevel(pinLevel), .senseEn(senseEn),
  .trigLevel(trigLevel), .trigInvert(trigInvert), .wrEnable(wrEnable),
  .statusOut(statusOut), .enableOut(enableOut), .irqOut(irqOut)
);

// File: tb/gpio_irq_aggregator_test.sv
module gpio_irq_aggregator_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 95;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pinLevel = '0, senseEn = '0, trigLevel = '0, trigInvert = '0;
  logic wrStatus = 1'b0, wrEnable = 1'b0;
  logic [1:0] wrWordSel = '0;
  logic [31:0] wrData = '0;
  logic [NP-1:0] statusOut, enableOut;
  logic irqOut;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_aggregator #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .pinLevel(pinLevel), .senseEn(senseEn),
    .trigLevel(trigLevel), .trigInvert(trigInvert), .wrStatus(wrStatus),
    .wrEnable(wrEnable), .wrWordSel(wrWordSel), .wrData(wrData),
    .statusOut(statusOut), .enableOut(enableOut), .irqOut(irqOut)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(bit st, bit en, int w, logic [31:0] d);
    wrStatus = st; wrEnable = en; wrWordSel = 2'(w); wrData = d;
    tick();
    wrStatus = 1'b0; wrEnable = 1'b0;
  endtask

  function automatic bit lvlHit(int m, bit l);
    return m[1] && (l == m[0]);
  endfunction

  function automatic bit evtHit(int m, bit p, bit c);
    if (m[1]) return c == m[0];
    if (m[0]) return p && !c;
    return !p && c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int pins[6] = '{0, 31, 32, 63, 64, 94};
    string tags[4] = '{"R1 rising", "R2 falling", "R3 level-low", "R4 level-high"};
    logic [NP-1:0] exp;

    // R12: rising-mode pin held high through reset
    pinLevel[7] = 1'b1; senseEn[7] = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check("R12 no event at first edge", 128'(statusOut), 128'(0));
    check("R10 reset enable", 128'(enableOut), 128'(0));
    check("R10 reset irq", 128'(irqOut), 128'(0));
    pinLevel = '0; senseEn = '0;

    // R1-R4, R8: sweep modes and transitions on word-boundary pins
    foreach (pins[i]) begin
      for (int m = 0; m < 4; m++) begin
        for (int t = 0; t < 4; t++) begin
          int p = pins[i];
          bit pv = t[1];
          bit cv = t[0];
          senseEn = '0; trigLevel = '0; trigInvert = '0; pinLevel = '0;
          senseEn[p] = 1'b1; trigLevel[p] = m[1]; trigInvert[p] = m[0];
          pinLevel[p] = pv;
          for (int w = 0; w < 3; w++) busWrite(0, 1, w, 32'h0);
          busWrite(0, 1, p / 32, 32'h1 << (p % 32));
          tick();
          for (int w = 0; w < 3; w++) busWrite(1, 0, w, 32'hFFFF_FFFF);
          pinLevel[p] = cv;
          tick();
          exp = '0;
          exp[p] = lvlHit(m, pv) | evtHit(m, pv, cv);
          check(tags[m], 128'(statusOut), 128'(exp));
          tick();
          check("R8 irq lag", 128'(irqOut), 128'(exp[p]));
        end
      end
    end

    // R9: sense disabled
    senseEn = '0; trigLevel = '0; trigInvert = '0; pinLevel = '0;
    for (int w = 0; w < 3; w++) busWrite(1, 0, w, 32'hFFFF_FFFF);
    pinLevel[10] = 1'b1; trigLevel[11] = 1'b1; trigInvert[11] = 1'b1; pinLevel[11] = 1'b1;
    tick(); tick();
    check("R9 sense off", 128'(statusOut), 128'(0));

    // R5: write-one-to-clear, zeros ignored
    senseEn = '0; pinLevel = '0; trigLevel = '0; trigInvert = '0;
    senseEn[3] = 1'b1; senseEn[40] = 1'b1;
    tick();
    pinLevel[3] = 1'b1; pinLevel[40] = 1'b1;
    tick();
    exp = '0; exp[3] = 1'b1; exp[40] = 1'b1;
    check("R5 both set", 128'(statusOut), 128'(exp));
    busWrite(1, 0, 1, 32'h0);
    check("R5 zero write no effect", 128'(statusOut), 128'(exp));
    busWrite(1, 0, 1, 32'h1 << 8);
    exp[40] = 1'b0;
    check("R5 clear pin 40 only", 128'(statusOut), 128'(exp));

    // R6: rising event on pin 5 with clear of word 0 at the same edge
    senseEn[5] = 1'b1;
    tick();
    pinLevel[5] = 1'b1;
    busWrite(1, 0, 0, 32'hFFFF_FFFF);
    check("R6 set wins pin 5", 128'(statusOut[5]), 128'(1));
    check("R6 pin 3 cleared", 128'(statusOut[3]), 128'(0));

    // R3: clear while level-low persists
    senseEn = '0; senseEn[20] = 1'b1; trigLevel[20] = 1'b1; trigInvert[20] = 1'b0;
    pinLevel[20] = 1'b0;
    tick();
    busWrite(1, 0, 0, 32'h1 << 20);
    tick();
    check("R3 level re-sets", 128'(statusOut[20]), 128'(1));

    // R7: enable word loads
    busWrite(0, 1, 2, 32'hFFFF_FFFF);
    check("R7 word2 load, top bit dropped", 128'(enableOut[94:64]), 128'(31'h7FFF_FFFF));
    busWrite(0, 1, 0, 32'hA5A5_A5A5);
    check("R7 word0 load", 128'(enableOut[31:0]), 128'(32'hA5A5_A5A5));
    check("R7 word2 kept", 128'(enableOut[94:64]), 128'(31'h7FFF_FFFF));

    // R11: out-of-range word index
    exp = enableOut;
    busWrite(0, 1, 3, 32'h0);
    check("R11 enable write ignored", 128'(enableOut), 128'(exp));
    exp = statusOut;
    busWrite(1, 0, 3, 32'hFFFF_FFFF);
    check("R11 status write ignored", 128'(statusOut), 128'(exp));

    // R10: initialization sequence leaves nothing pending
    busWrite(0, 1, 0, 32'hFFFF_FFFF);
    tick(); tick();
    check("R10 irq before init", 128'(irqOut), 128'(1));
    for (int w = 0; w < 3; w++) begin
      busWrite(1, 0, w, 32'hFFFF_FFFF);
      busWrite(0, 1, w, 32'h0);
    end
    tick(); tick();
    check("R10 irq after init", 128'(irqOut), 128'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule